// File: doc/BRIEF.md
# Self-Correcting Johnson Timing Generator

This block produces a repeating train of eight non-overlapping timing strobes for sequencing the steps of a controller. Four flip-flops form a circular shift chain. The inverted value of the last stage is fed back into the first stage, so the chain walks through eight distinct patterns. Each strobe comes from a two-input AND of two stage bits. In every legal pattern exactly one strobe is high.

A plain switch-tail chain has eight unused patterns, and these form loops of their own. Noise or an upset that lands the chain in one of them would leave the strobes scrambled for good. The input of the third stage is therefore not a plain copy of its neighbour. It also depends on the first stage and on its own present value. On legal patterns this makes no difference, and every unused pattern drains back into the legal cycle within a few enabled clocks.

An enable input lets the sequence pause. A synchronous reset returns the chain to a known pattern, which is a parameter and defaults to all zeros. The number of stages is also a parameter, but the recovery term is only inserted when the chain has four stages.

Top module: `jtg_timing_gen`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `state_o` becomes `INIT_STATE` (default 4'b0000), and with the default `timing_o` is then 8'b0000_0001.
- R2: On an enabled edge, `state_o[3]` takes the inverse of the previous `state_o[0]`.
- R3: On an enabled edge, `state_o[2]` takes the previous `state_o[3]`, and `state_o[0]` takes the previous `state_o[1]`.
- R4: On an enabled edge, `state_o[1]` takes (previous `state_o[3]` OR previous `state_o[1]`) AND previous `state_o[2]`.
- R5: From 4'b0000, enabled edges visit 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 (written `state_o[3:0]`) and then return to 0000, repeating with a period of eight. A legal pattern never steps to an illegal one.
- R6: In the k-th pattern of the R5 list (k = 0..7), `timing_o` equals 1 shifted left by k, so it is one-hot.
- R7: When `en_i` is low and `rst_i` is low, `state_o` and `timing_o` keep their values across the edge.
- R8: Whatever the starting pattern among all 16, the chain is on the R5 cycle after at most five enabled edges. The pattern 1010 needs exactly five.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high, loads `INIT_STATE` |
| en_i | input | 1 | Advance the chain on this edge when high |
| state_o | output | STAGES | Stage bits, bit STAGES-1 is the first stage |
| timing_o | output | 2*STAGES | Decoded timing strobes, bit k for the k-th pattern |

## Verification
The bench instantiates sixteen copies of the block, each reset into a different pattern, so that every legal and every illegal starting pattern is covered in the same run. A mistake in the recovery term shows up in one of two ways. Some copy either never reaches the legal cycle or stays outside it for more than five steps. Or a legal pattern is bent off its sequence, which would make the strobes skip or double. Enable is held low on scattered cycles. A design that let a held cycle leak a shift would drift away from the reference count. A decode wired to the wrong stage pair would raise two strobes, or none, in some legal pattern.

// File: rtl/jtg_pkg.sv
package jtg_pkg;

    // Chain length for which the recovery term is defined
    localparam int unsigned JTG_CORR_STAGES = 4;

    // A legal switch-tail pattern has at most one change between
    // neighbouring stage bits when read from the first stage to the last.
    function automatic logic jtg_is_legal(input logic [31:0] pat, input int unsigned n);
        int unsigned edges;
        edges = 0;
        for (int unsigned i = 1; i < n; i++) begin
            if (pat[i] != pat[i-1]) edges++;
        end
        return (edges <= 1);
    endfunction

endpackage

// File: rtl/jtg_next.sv
// Next-pattern logic of the switch-tail chain, with the recovery term on
// the third stage when the chain has the length it is defined for.
module jtg_next #(
    parameter int unsigned STAGES = 4
) (
    input  logic [STAGES-1:0] cur_i,
    output logic [STAGES-1:0] nxt_o
);
    import jtg_pkg::*;

    localparam int unsigned FIRST   = STAGES - 1;
    localparam bit          USE_FIX = (STAGES == JTG_CORR_STAGES);

    // Inverted tail feeds the head
    assign nxt_o[FIRST] = ~cur_i[0];

    for (genvar i = 0; i < STAGES - 1; i++) begin : g_stage
        if (USE_FIX && i == 1) begin : g_fix
            // third stage: (first OR self) AND second
            assign nxt_o[i] = (cur_i[3] | cur_i[1]) & cur_i[2];
        end else begin : g_plain
            assign nxt_o[i] = cur_i[i+1];
        end
    end

endmodule

// File: rtl/jtg_decode.sv
// Two-input AND decode of the 2*STAGES legal patterns into strobes.
module jtg_decode #(
    parameter int unsigned STAGES = 4
) (
    input  logic [STAGES-1:0]   stage_i,
    output logic [2*STAGES-1:0] tap_o
);
    localparam int unsigned TAPS = 2 * STAGES;
    localparam int unsigned TOP  = STAGES - 1;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_all_low
            assign tap_o[k] = ~stage_i[TOP] & ~stage_i[0];
        end else if (k < STAGES) begin : g_fill
            // last one of the leading ones, first zero behind it
            assign tap_o[k] = stage_i[STAGES-k] & ~stage_i[STAGES-1-k];
        end else if (k == STAGES) begin : g_all_high
            assign tap_o[k] = stage_i[TOP] & stage_i[0];
        end else begin : g_drain
            // last zero of the leading zeros, first one behind it
            assign tap_o[k] = ~stage_i[TAPS-k] & stage_i[TAPS-1-k];
        end
    end

endmodule

// File: rtl/jtg_timing_gen.sv
module jtg_timing_gen #(
    parameter int unsigned        STAGES     = 4,
    parameter logic [STAGES-1:0]  INIT_STATE = '0
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  en_i,
    output logic [STAGES-1:0]     state_o,
    output logic [2*STAGES-1:0]   timing_o
);
    localparam int unsigned TAPS = 2 * STAGES;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } jtg_reg_t;

    jtg_reg_t          reg_d, reg_q;
    logic [STAGES-1:0] step_w;
    logic [TAPS-1:0]   tap_w;

    jtg_next #(.STAGES(STAGES)) u_next (
        .cur_i (reg_q.chain),
        .nxt_o (step_w)
    );

    always_comb begin
        reg_d = reg_q;
        if (en_i) begin
            reg_d.chain = step_w;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            reg_q.chain <= INIT_STATE;
        end else begin
            reg_q <= reg_d;
        end
    end

    jtg_decode #(.STAGES(STAGES)) u_decode (
        .stage_i (reg_q.chain),
        .tap_o   (tap_w)
    );

    assign state_o  = reg_q.chain;
    assign timing_o = tap_w;

endmodule

// File: rtl/jtg_timing_chk.sv
module jtg_timing_chk #(
    parameter int unsigned        STAGES     = 4,
    parameter logic [STAGES-1:0]  INIT_STATE = '0
) (
    input logic                   clk_i,
    input logic                   rst_i,
    input logic                   en_i,
    input logic [STAGES-1:0]      state_o,
    input logic [2*STAGES-1:0]    timing_o
);
    import jtg_pkg::*;

    logic legal_w;
    assign legal_w = jtg_is_legal(32'(state_o), STAGES);

    // R1
    reset_value_chk: assert property (@(posedge clk_i)
        rst_i |=> state_o == INIT_STATE);

    // R2
    tail_invert_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> state_o[STAGES-1] == !$past(state_o[0]));

    // R3
    last_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> state_o[0] == $past(state_o[1]));

    // R5
    legal_closed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && legal_w) |=> legal_w);

    // R6
    strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        legal_w |-> $countones(timing_o) == 1);

    // R7
    hold_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(state_o) && $stable(timing_o));

    if (STAGES == JTG_CORR_STAGES) begin : g_recover
        logic [3:0] bad_run_q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                bad_run_q <= '0;
            end else if (legal_w) begin
                bad_run_q <= '0;
            end else if (en_i && bad_run_q != 4'hF) begin
                bad_run_q <= bad_run_q + 4'd1;
            end
        end

        // R8
        recover_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            bad_run_q <= 4'd5);
    end

endmodule

bind jtg_timing_gen jtg_timing_chk #(
    .STAGES     (STAGES),
    .INIT_STATE (INIT_STATE)
) u_jtg_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .state_o  (state_o),
    .timing_o (timing_o)
);

// File: tb/tb_jtg_timing_gen.sv
`timescale 1ns/100ps
module tb_jtg_timing_gen;

    localparam int NINST = 16;
    localparam int WATCHDOG = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;

    logic [3:0] st [NINST];
    logic [7:0] tm [NINST];

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < NINST; g++) begin : g_dut
        jtg_timing_gen #(.STAGES(4), .INIT_STATE(4'(g))) dut (
            .clk_i    (clk),
            .rst_i    (rst),
            .en_i     (en),
            .state_o  (st[g]),
            .timing_o (tm[g])
        );
    end

    // legal cycle in visiting order
    int seq[$] = '{0, 8, 12, 14, 15, 7, 3, 1};

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit running = 0;

    int model [NINST];
    int prev_model [NINST];
    int bad_run [NINST];
    int worst_run = 0;
    bit rst_prev = 1'b1;
    bit en_prev = 1'b0;

    function automatic int seq_pos(input int s);
        foreach (seq[i]) if (seq[i] == s) return i;
        return -1;
    endfunction

    // behaviour from R2..R5: legal patterns follow the listed order,
    // illegal ones follow the per-stage rules
    function automatic int step_of(input int s);
        int p, a, b, c, e;
        p = seq_pos(s);
        if (p >= 0) return seq[(p + 1) % 8];
        a = (s >> 3) & 1; b = (s >> 2) & 1; c = (s >> 1) & 1; e = s & 1;
        return ((1 - e) << 3) | (a << 2) | (((a | c) & b) << 1) | c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        for (int g = 0; g < NINST; g++) begin
            prev_model[g] <= model[g];
            if (rst) begin
                model[g]   <= g;
                bad_run[g] <= 0;
            end else if (en) begin
                model[g] <= step_of(model[g]);
                if (seq_pos(model[g]) < 0) bad_run[g] <= bad_run[g] + 1;
                else bad_run[g] <= 0;
            end
        end
        rst_prev <= rst;
        en_prev  <= en;
    end

    always @(negedge clk) begin
        if (running) begin
            for (int g = 0; g < NINST; g++) begin
                int exp, act, p;
                exp = model[g];
                act = int'(st[g]);
                p   = seq_pos(exp);
                if (rst_prev) begin
                    check(act == g, "R1", act, g);
                end else if (!en_prev) begin
                    check(act == exp, "R7", act, exp);
                end else begin
                    check(st[g][3] == exp[3], "R2", int'(st[g][3]), exp[3]);
                    check(st[g][2] == exp[2] && st[g][0] == exp[0], "R3", act, exp);
                    check(st[g][1] == exp[1], "R4", int'(st[g][1]), exp[1]);
                    if (seq_pos(prev_model[g]) >= 0)
                        check(act == exp, "R5", act, exp);
                end
                if (p >= 0)
                    check(int'(tm[g]) == (1 << p), "R6", int'(tm[g]), 1 << p);
                if (bad_run[g] > worst_run) worst_run = bad_run[g];
                check(bad_run[g] <= 5 && !(bad_run[g] == 5 && p < 0), "R8", bad_run[g], 5);
            end
        end
    end

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        report();
    end

    initial begin
        rst = 1'b1; en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        running = 1;
        // R1: default-reset copy shows first strobe
        check(int'(tm[0]) == 1, "R1", int'(tm[0]), 1);
        @(negedge clk);
        rst = 1'b0;
        // held after reset: R7
        repeat (3) @(negedge clk);
        en = 1'b1;
        // all enabled so every illegal start drains: R8
        repeat (20) @(negedge clk);
        check(worst_run == 5, "R8", worst_run, 5);
        for (int g = 0; g < NINST; g++)
            check(seq_pos(int'(st[g])) >= 0, "R8", int'(st[g]), 0);
        // scattered holds: R7 and R5
        for (int n = 0; n < 120; n++) begin
            en = (n % 3 != 1) && (n % 7 != 5);
            @(negedge clk);
        end
        // reset in the middle of a run: R1
        rst = 1'b1; en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (24) @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        running = 0;
        report();
    end

endmodule